// File: doc/BRIEF.md
# Channel Command and Mode Controller

This block is the control core of one channel of a descriptor-driven engine that can XOR sources together, copy memory, compute a CRC32 over a buffer or fill memory with a pattern. It tracks whether the channel is idle, active or paused. It takes single-cycle command pulses (start, stop, pause, restart) and allows only the transitions that are legal from the current state. It also owns the channel configuration word, whose low two bits select the operation.

A new job is requested through a dedicated setup port that carries the operation and the next-descriptor pointer. The block refuses the request while the channel is running. For descriptor-based operations it also refuses a pointer that is zero or misaligned for the chosen operation. An accepted request loads the mode and pointer, moves the channel to active and sends a one-cycle launch strobe to the datapath. When the datapath reports completion, the channel returns to idle and a done pulse is raised. Every result appears on registered outputs one clock after the input that caused it.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, status is idle (code 0), desc_ptr is 0 and cfg_rdata is 0x0448. This reset word has mode 0, the protection bit (bit 3) set, and the value 4 in both the source burst field [6:4] and the destination burst field [10:8]. Status codes are idle 0, active 1 and paused 2, and code 3 never appears.
- R2: A start command (cmd_code 0) from idle or paused makes the channel active and pulses launch. From active it pulses cmd_err.
- R3: A stop command (cmd_code 1) moves active to idle. Issued while idle, it changes nothing and raises no error. Issued while paused, it pulses cmd_err.
- R4: A pause command (cmd_code 2) moves active to paused. From any other state it pulses cmd_err.
- R5: A restart command (cmd_code 3) moves paused to active without a launch pulse. From any other state it pulses cmd_err.
- R6: A command that pulses cmd_err leaves the status unchanged.
- R7: A setup request while active pulses setup_busy and leaves the mode, desc_ptr and status unchanged.
- R8: Setup modes are 0 XOR, 1 copy, 2 CRC32 and 3 fill. Modes 0 to 2 reject a zero pointer. Mode 0 also requires ptr[5:0] = 0, and modes 1 and 2 require ptr[4:0] = 0. Mode 3 accepts any pointer. A rejected request pulses setup_bad and changes nothing.
- R9: An accepted setup, from idle or paused, loads the mode into cfg_rdata[1:0] and the pointer into desc_ptr, makes the channel active and pulses launch.
- R10: A general configuration write replaces every cfg bit except the mode field [1:0], which only an accepted setup can change. Without a write, the bits above the mode field hold their value.
- R11: dp_done while active returns the channel to idle and pulses done.
- R12: When dp_done arrives while active, a command or setup in the same cycle is dropped silently, with no cmd_err, setup_busy, setup_bad or launch.
- R13: dp_done while idle or paused is ignored: no done pulse and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command pulse |
| cmd_code | input | 2 | 0 start, 1 stop, 2 pause, 3 restart |
| setup_valid | input | 1 | New-job request |
| setup_mode | input | 2 | Requested operation |
| setup_ptr | input | ADDR_W | Next-descriptor (or fill destination) pointer |
| cfg_wr | input | 1 | General configuration write |
| cfg_wdata | input | CFG_W | Configuration write data |
| dp_done | input | 1 | Datapath completion |
| status | output | 2 | Channel state code |
| cfg_rdata | output | CFG_W | Configuration word |
| desc_ptr | output | ADDR_W | Pointer of the accepted job |
| launch | output | 1 | One-cycle start strobe to the datapath |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Illegal command pulse |
| setup_busy | output | 1 | Setup refused because active |
| setup_bad | output | 1 | Setup refused for its pointer |

## Verification
The bench drives every command from every state. A design with a wrong transition table would, for example, accept pause while paused, or flag the harmless stop issued while idle. Setup pointers are swept over all low seven bits, with and without a high bit set, in every mode. This catches an off-by-one alignment width, a missing zero check, or a fill mode that wrongly applies the alignment rule. Further directed cases cover a general write that tries to alter the mode, setup while busy or paused, completion colliding with a command, and stray completions while idle or paused. Each of these would show up as a changed mode, a lost done pulse or a spurious error flag.

// File: rtl/chan_ctrl_pkg.sv
package chan_ctrl_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [1:0] {
      CH_IDLE   = 2'd0,
      CH_ACTIVE = 2'd1,
      CH_PAUSED = 2'd2
   } ch_state_e;

   typedef enum logic [1:0] {
      OP_START  = 2'd0,
      OP_STOP   = 2'd1,
      OP_PAUSE  = 2'd2,
      OP_RESUME = 2'd3
   } ch_cmd_e;

   typedef enum logic [1:0] {
      MD_XOR  = 2'd0,
      MD_COPY = 2'd1,
      MD_CRC  = 2'd2,
      MD_FILL = 2'd3
   } ch_mode_e;
endpackage

// File: rtl/chan_ptr_check.sv
module chan_ptr_check
   import chan_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int XOR_ALIGN  = 6,
   parameter int STRM_ALIGN = 5,
   parameter bit FILL_EN    = 1'b1
) (
   input  ch_mode_e            mode,
   input  logic [ADDR_W-1:0]   ptr,
   output logic                ok
);
   localparam logic [ADDR_W-1:0] XOR_MASK  = ADDR_W'((64'd1 << XOR_ALIGN) - 64'd1);
   localparam logic [ADDR_W-1:0] STRM_MASK = ADDR_W'((64'd1 << STRM_ALIGN) - 64'd1);

   logic nonzero, xor_ok, strm_ok, fill_ok;

   assign nonzero = |ptr;
   assign xor_ok  = nonzero && ((ptr & XOR_MASK) == '0);
   assign strm_ok = nonzero && ((ptr & STRM_MASK) == '0);

   generate
      if (FILL_EN) begin : g_fill_on
         assign fill_ok = 1'b1;
      end else begin : g_fill_off
         assign fill_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         MD_XOR:          ok = xor_ok;
         MD_COPY, MD_CRC: ok = strm_ok;
         default:         ok = fill_ok;
      endcase
   end
endmodule

// File: rtl/chan_cfg_reg.sv
module chan_cfg_reg
   import chan_ctrl_pkg::*;
#(
   parameter int CFG_W     = 16,
   parameter int PROT_BIT  = 3,
   parameter int SRC_LSB   = 4,
   parameter int DST_LSB   = 8,
   parameter int BURST_W   = 3,
   parameter int BURST_RST = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [CFG_W-1:0]   wr_data,
   input  logic               mode_ld,
   input  logic [MODE_W-1:0]  mode_in,
   output logic [CFG_W-1:0]   cfg_q
);
   localparam logic [CFG_W-1:0] MODE_MASK = CFG_W'((1 << MODE_W) - 1);
   localparam logic [CFG_W-1:0] BURST_V   = CFG_W'(BURST_RST) & CFG_W'((1 << BURST_W) - 1);
   localparam logic [CFG_W-1:0] RST_VAL   = (CFG_W'(1) << PROT_BIT)
                                          | (BURST_V << SRC_LSB)
                                          | (BURST_V << DST_LSB);

   logic [CFG_W-1:0] cfg_d;

   always_comb begin
      cfg_d = cfg_q;
      if (wr_en) begin
         cfg_d = (cfg_q & MODE_MASK) | (wr_data & ~MODE_MASK);
      end
      if (mode_ld) begin
         cfg_d = (cfg_d & ~MODE_MASK) | CFG_W'(mode_in);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= RST_VAL;
      else        cfg_q <= cfg_d;
   end
endmodule

// File: rtl/chan_cmd_fsm.sv
module chan_cmd_fsm
   import chan_ctrl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [1:0]  cmd_code,
   input  logic        setup_valid,
   input  logic        setup_ok,
   input  logic        dp_done,
   output ch_state_e   state_q,
   output logic        launch_q,
   output logic        done_q,
   output logic        err_q,
   output logic        busy_q,
   output logic        bad_q,
   output logic        take
);
   ch_state_e state_d;
   logic      launch_d, err_d, busy_d, bad_d, fin;

   assign fin = dp_done && (state_q == CH_ACTIVE);

   always_comb begin
      state_d  = state_q;
      launch_d = 1'b0;
      err_d    = 1'b0;
      busy_d   = 1'b0;
      bad_d    = 1'b0;
      take     = 1'b0;
      if (fin) begin
         state_d = CH_IDLE;
      end else if (cmd_valid) begin
         unique case (ch_cmd_e'(cmd_code))
            OP_START: begin
               if (state_q != CH_ACTIVE) begin
                  state_d  = CH_ACTIVE;
                  launch_d = 1'b1;
               end else err_d = 1'b1;
            end
            OP_STOP: begin
               if (state_q == CH_ACTIVE)      state_d = CH_IDLE;
               else if (state_q == CH_PAUSED) err_d   = 1'b1;
            end
            OP_PAUSE: begin
               if (state_q == CH_ACTIVE) state_d = CH_PAUSED;
               else                      err_d   = 1'b1;
            end
            default: begin
               if (state_q == CH_PAUSED) state_d = CH_ACTIVE;
               else                      err_d   = 1'b1;
            end
         endcase
      end else if (setup_valid) begin
         if (state_q == CH_ACTIVE) begin
            busy_d = 1'b1;
         end else if (!setup_ok) begin
            bad_d = 1'b1;
         end else begin
            take     = 1'b1;
            state_d  = CH_ACTIVE;
            launch_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CH_IDLE;
         launch_q <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         busy_q   <= 1'b0;
         bad_q    <= 1'b0;
      end else begin
         state_q  <= state_d;
         launch_q <= launch_d;
         done_q   <= fin;
         err_q    <= err_d;
         busy_q   <= busy_d;
         bad_q    <= bad_d;
      end
   end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import chan_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CFG_W      = 16,
   parameter int XOR_ALIGN  = 6,
   parameter int STRM_ALIGN = 5,
   parameter int BURST_W    = 3,
   parameter int BURST_RST  = 4,
   parameter int PROT_BIT   = 3,
   parameter int SRC_LSB    = 4,
   parameter bit FILL_EN    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_code,
   input  logic               setup_valid,
   input  logic [1:0]         setup_mode,
   input  logic [ADDR_W-1:0]  setup_ptr,
   input  logic               cfg_wr,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               dp_done,
   output logic [1:0]         status,
   output logic [CFG_W-1:0]   cfg_rdata,
   output logic [ADDR_W-1:0]  desc_ptr,
   output logic               launch,
   output logic               done,
   output logic               cmd_err,
   output logic               setup_busy,
   output logic               setup_bad
);
   localparam int DST_LSB = SRC_LSB + BURST_W + 1;

   generate
      if (CFG_W < DST_LSB + BURST_W) begin : g_err_cfg_w
         $error("CFG_W too small for the burst fields");
      end
      if (PROT_BIT < MODE_W || PROT_BIT >= SRC_LSB) begin : g_err_prot
         $error("PROT_BIT must sit between the mode field and the source burst field");
      end
      if (XOR_ALIGN >= ADDR_W || STRM_ALIGN >= ADDR_W || XOR_ALIGN < 1 || STRM_ALIGN < 1) begin : g_err_align
         $error("alignment widths must be within 1..ADDR_W-1");
      end
      if (BURST_RST >= (1 << BURST_W)) begin : g_err_burst
         $error("BURST_RST does not fit BURST_W");
      end
   endgenerate

   ch_state_e state_q;
   logic      ptr_ok, take;

   chan_ptr_check #(
      .ADDR_W     (ADDR_W),
      .XOR_ALIGN  (XOR_ALIGN),
      .STRM_ALIGN (STRM_ALIGN),
      .FILL_EN    (FILL_EN)
   ) ptr_chk_i (
      .mode (ch_mode_e'(setup_mode)),
      .ptr  (setup_ptr),
      .ok   (ptr_ok)
   );

   chan_cmd_fsm fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_code    (cmd_code),
      .setup_valid (setup_valid),
      .setup_ok    (ptr_ok),
      .dp_done     (dp_done),
      .state_q     (state_q),
      .launch_q    (launch),
      .done_q      (done),
      .err_q       (cmd_err),
      .busy_q      (setup_busy),
      .bad_q       (setup_bad),
      .take        (take)
   );

   chan_cfg_reg #(
      .CFG_W     (CFG_W),
      .PROT_BIT  (PROT_BIT),
      .SRC_LSB   (SRC_LSB),
      .DST_LSB   (DST_LSB),
      .BURST_W   (BURST_W),
      .BURST_RST (BURST_RST)
   ) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wr_data (cfg_wdata),
      .mode_ld (take),
      .mode_in (setup_mode),
      .cfg_q   (cfg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    desc_ptr <= '0;
      else if (take) desc_ptr <= setup_ptr;
   end

   assign status = state_q;
endmodule

// File: rtl/chan_ctrl_chk.sv
module chan_ctrl_chk #(
   parameter int ADDR_W = 32,
   parameter int CFG_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic [1:0]         cmd_code,
   input logic               setup_valid,
   input logic               cfg_wr,
   input logic               dp_done,
   input logic [1:0]         status,
   input logic [CFG_W-1:0]   cfg_rdata,
   input logic [ADDR_W-1:0]  desc_ptr,
   input logic               launch,
   input logic               done,
   input logic               cmd_err,
   input logic               setup_busy,
   input logic               setup_bad
);
   // R1: only the three legal status codes appear
   a_r1_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
      status != 2'd3);

   // R2 / R9: a launch always lands in the active state
   a_r2_launch_active: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> status == 2'd1);

   // R5: restart never launches
   a_r5_resume_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 2'd3) |=> !launch);

   // R6: an error pulse means the state did not move
   a_r6_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> status == $past(status));

   // R7: a busy refusal keeps the channel active and the pointer
   a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      setup_busy |-> (status == 2'd1 && $stable(desc_ptr) && $stable(cfg_rdata[1:0])));

   // R8: a bad pointer changes nothing
   a_r8_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
      setup_bad |-> ($stable(desc_ptr) && $stable(cfg_rdata[1:0]) && status == $past(status)));

   // R10: general writes never touch the mode field
   a_r10_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !setup_valid) |=> $stable(cfg_rdata[1:0]));

   // R10: upper configuration bits change only by a write
   a_r10_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_rdata[CFG_W-1:2]));

   // R11: done is a return from active to idle
   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status == 2'd0 && $past(status) == 2'd1));

   // R12: completion wins over a same-cycle command or setup
   a_r12_done_first: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_done && status == 2'd1) |=> (done && !cmd_err && !setup_busy && !setup_bad && !launch));

   // R13: stray completion is ignored
   a_r13_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_done && status != 2'd1 && !cmd_valid && !setup_valid) |=> (!done && $stable(status)));
endmodule

bind dma_chan_ctrl chan_ctrl_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_code    (cmd_code),
   .setup_valid (setup_valid),
   .cfg_wr      (cfg_wr),
   .dp_done     (dp_done),
   .status      (status),
   .cfg_rdata   (cfg_rdata),
   .desc_ptr    (desc_ptr),
   .launch      (launch),
   .done        (done),
   .cmd_err     (cmd_err),
   .setup_busy  (setup_busy),
   .setup_bad   (setup_bad)
);

// File: tb/dma_chan_ctrl_tb_top.sv
module dma_chan_ctrl_tb_top;
   localparam int AW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_code = 2'd0;
   logic          setup_valid = 1'b0;
   logic [1:0]    setup_mode = 2'd0;
   logic [AW-1:0] setup_ptr = '0;
   logic          cfg_wr = 1'b0;
   logic [CW-1:0] cfg_wdata = '0;
   logic          dp_done = 1'b0;
   logic [1:0]    status;
   logic [CW-1:0] cfg_rdata;
   logic [AW-1:0] desc_ptr;
   logic          launch, done, cmd_err, setup_busy, setup_bad;

   int n_chk = 0;
   int n_fail = 0;
   logic [AW-1:0] last_ptr = '0;

   always #10 clk = ~clk;

   dma_chan_ctrl dut_i (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_code (cmd_code),
      .setup_valid (setup_valid), .setup_mode (setup_mode), .setup_ptr (setup_ptr),
      .cfg_wr (cfg_wr), .cfg_wdata (cfg_wdata), .dp_done (dp_done),
      .status (status), .cfg_rdata (cfg_rdata), .desc_ptr (desc_ptr),
      .launch (launch), .done (done), .cmd_err (cmd_err),
      .setup_busy (setup_busy), .setup_bad (setup_bad)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic quiet();
      cmd_valid = 1'b0; setup_valid = 1'b0; cfg_wr = 1'b0; dp_done = 1'b0;
   endtask

   task automatic send_cmd(input logic [1:0] c);
      cmd_valid = 1'b1; cmd_code = c; tick(); quiet();
   endtask

   task automatic finish_job();
      dp_done = 1'b1; tick(); quiet();
   endtask

   task automatic to_idle();
      while (status != 2'd0) begin
         if (status == 2'd2) send_cmd(2'd0);
         else finish_job();
      end
   endtask

   task automatic go_state(input int s);
      to_idle();
      if (s >= 1) send_cmd(2'd0);
      if (s == 2) send_cmd(2'd2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 status", 32'(status), 32'd0);
      chk("R1 cfg", 32'(cfg_rdata), 32'h0448);
      chk("R1 ptr", desc_ptr, 32'd0);

      // R2..R6 command sweep over every state
      for (int s = 0; s < 3; s++) begin
         for (int c = 0; c < 4; c++) begin
            int  exp_s;
            bit  exp_e, exp_l;
            go_state(s);
            exp_s = s; exp_e = 1'b0; exp_l = 1'b0;
            case (c)
               0: if (s != 1) begin exp_s = 1; exp_l = 1'b1; end else exp_e = 1'b1;
               1: if (s == 1) exp_s = 0; else if (s == 2) exp_e = 1'b1;
               2: if (s == 1) exp_s = 2; else exp_e = 1'b1;
               default: if (s == 2) exp_s = 1; else exp_e = 1'b1;
            endcase
            send_cmd(2'(c));
            chk($sformatf("R2-cmd%0d-st%0d status (R3 R4 R5)", c, s), 32'(status), 32'(exp_s));
            chk($sformatf("R6 err cmd%0d st%0d", c, s), 32'(cmd_err), 32'(exp_e));
            chk($sformatf("R5 launch cmd%0d st%0d", c, s), 32'(launch), 32'(exp_l));
         end
      end

      // R8 / R9 / R11 setup sweep
      to_idle();
      for (int md = 0; md < 4; md++) begin
         for (int hi = 0; hi < 2; hi++) begin
            for (int lo = 0; lo < 128; lo++) begin
               logic [AW-1:0] p;
               bit ok;
               p = (hi != 0 ? 32'h8000_0000 : 32'h0) | 32'(lo);
               if (md == 3)      ok = 1'b1;
               else if (p == 0)  ok = 1'b0;
               else if (md == 0) ok = (p[5:0] == 6'd0);
               else              ok = (p[4:0] == 5'd0);
               setup_valid = 1'b1; setup_mode = 2'(md); setup_ptr = p;
               tick(); quiet();
               chk("R8 launch", 32'(launch), 32'(ok));
               chk("R8 bad", 32'(setup_bad), 32'(!ok));
               if (ok) begin
                  chk("R9 ptr", desc_ptr, p);
                  chk("R9 mode", 32'(cfg_rdata[1:0]), 32'(md));
                  chk("R9 status", 32'(status), 32'd1);
                  last_ptr = p;
                  finish_job();
                  chk("R11 done", 32'(done), 32'd1);
                  chk("R11 status", 32'(status), 32'd0);
               end else begin
                  chk("R8 ptr kept", desc_ptr, last_ptr);
                  chk("R8 status", 32'(status), 32'd0);
               end
            end
         end
      end

      // R10 general write keeps mode (mode is 3 now)
      cfg_wr = 1'b1; cfg_wdata = 16'hFFFC; tick(); quiet();
      chk("R10 write1", 32'(cfg_rdata), 32'h0000FFFF);
      cfg_wr = 1'b1; cfg_wdata = 16'h1231; tick(); quiet();
      chk("R10 write2", 32'(cfg_rdata), 32'h00001233);
      cfg_wr = 1'b1; cfg_wdata = 16'h0440; setup_valid = 1'b1; setup_mode = 2'd1;
      setup_ptr = 32'h0000_0200; tick(); quiet();
      chk("R10 write+setup", 32'(cfg_rdata), 32'h00000441);
      last_ptr = 32'h0000_0200;

      // R7 setup while active
      setup_valid = 1'b1; setup_mode = 2'd0; setup_ptr = 32'h0000_1000; tick(); quiet();
      chk("R7 busy", 32'(setup_busy), 32'd1);
      chk("R7 ptr", desc_ptr, last_ptr);
      chk("R7 mode", 32'(cfg_rdata[1:0]), 32'd1);
      chk("R7 status", 32'(status), 32'd1);

      // R9 setup from paused
      send_cmd(2'd2);
      setup_valid = 1'b1; setup_mode = 2'd2; setup_ptr = 32'h0000_0020; tick(); quiet();
      chk("R9 paused launch", 32'(launch), 32'd1);
      chk("R9 paused status", 32'(status), 32'd1);
      chk("R9 paused ptr", desc_ptr, 32'h0000_0020);

      // R12 completion collides with a command, then with a setup
      cmd_valid = 1'b1; cmd_code = 2'd2; dp_done = 1'b1; tick(); quiet();
      chk("R12 done", 32'(done), 32'd1);
      chk("R12 err", 32'(cmd_err), 32'd0);
      chk("R12 status", 32'(status), 32'd0);
      send_cmd(2'd0);
      setup_valid = 1'b1; setup_mode = 2'd0; setup_ptr = 32'h0000_0040; dp_done = 1'b1;
      tick(); quiet();
      chk("R12 setup busy", 32'(setup_busy), 32'd0);
      chk("R12 setup launch", 32'(launch), 32'd0);
      chk("R12 setup ptr", desc_ptr, 32'h0000_0020);

      // R13 stray completions
      finish_job();
      chk("R13 idle done", 32'(done), 32'd0);
      chk("R13 idle status", 32'(status), 32'd0);
      go_state(2);
      finish_job();
      chk("R13 paused done", 32'(done), 32'd0);
      chk("R13 paused status", 32'(status), 32'd2);

      report();
   end
endmodule